// File: doc/BRIEF.md
# BCD Calendar Timekeeper Register Block

This block keeps wall-clock time in packed BCD: seconds, minutes, hours, day of week, date, month, a two-digit year and a separate two-digit century. It advances by one second for each single-cycle pulse on its tick input. The day-of-month limit follows the month, and leap years follow the Gregorian rules. A host reaches the block through a byte-wide synchronous bus with a sixteen-byte window. A write is taken on the clock edge. Read data is combinational from the address.

Two control bits in the flags byte handle access. The capture bit freezes a coherent copy of every time field, so a multi-byte read cannot tear across a carry, and the live counters keep running behind it. The staging bit opens a window: time-byte writes collect in a shadow set, and when the bit is cleared they are applied to the live counters together on one edge. A halt bit in the calibration byte holds the counters, and it comes out of reset set. The alarm, interrupt-enable and watchdog bytes are plain storage.

Top module: `rtc_bcd_core`

## Requirements
- R1: Offsets 2 to 7 (four alarm bytes, interrupt enables, watchdog) store a full byte each and read back what was written.
- R2: After reset the time reads century 0x20, year 0x00, month 0x01, date 0x01, day of week 1, and 00:00:00. The flags byte reads 0x00 when the low-voltage pin is low, and the calibration byte (offset 8) reads 0x80.
- R3: Bit 7 of offset 8 is the halt bit, and ticks have no effect while it is set. Bits 5:0 hold a stored trim value, and bit 6 reads as zero.
- R4: Writing 1 to bit 1 of the flags byte (offset 0) copies the live time into a staging set. While that bit is set, writes to offsets 1 and 9 to 15 change only the staging set, and reads still return the live time. Writing 0 to the bit applies the whole staging set, so ticks taken during the window do not appear in the result. Time-byte writes made while the bit is clear are ignored.
- R5: Writing 1 to bit 0 of the flags byte, when it was 0, captures all time fields. While the bit stays set, time reads return the captured copy and the live counters keep advancing. After the bit is cleared, reads return live time again.
- R6: Seconds and minutes roll over from 0x59 to 0x00, and hours from 0x23 to 0x00, each carrying into the next field.
- R7: The date wraps to 0x01 after the last day of the month (30 or 31, and February 28 or 29). A year is a leap year when it is divisible by 4, except that year 00 is a leap year only when the century is divisible by 4. Month 0x12 wraps to 0x01. Year 0x99 wraps to 0x00 and increments the century, and century 0x99 wraps to 0x00.
- R8: The day of week (offset 12) steps 1 to 7 and then back to 1, once per date change.
- R9: Unused upper bits read as zero. The fields have these widths: seconds 7 bits, minutes 7, hours 6, date 6, month 5, day of week 3.
- R10: Flags bit 5 reflects the low-voltage input pin. Flags bits 7:6 and 4:2 always read zero, and writes cannot set them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse, one per second |
| lowv_i | input | 1 | Low-voltage indication, shown in flags bit 5 |
| bus_addr_i | input | 4 | Byte offset within the window |
| bus_wr_i | input | 1 | Write strobe, taken at the clock edge |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i (combinational) |

## Verification
The bench uses the default parameters, so the block starts at 2000-01-01, day 1, with the clock halted. That reset point lets the halt-bit and trim checks run before any time has been written. The reset century 20 is divisible by four, which puts the leap-year exception in the century rule within reach of the directed dates: 2000-02-28, 2100-02-28 and 9999-12-31 are set through the staging window. Random valid dates followed by long bursts of ticks then cross many month and year boundaries, and each result is read back through the capture bit.

// File: rtl/rtc_bcd_pkg.sv
package rtc_bcd_pkg;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;
    localparam int MISC_N = 6;

    localparam logic [ADDR_W-1:0] OFS_FLAGS = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_CENT  = 4'h1;
    localparam logic [ADDR_W-1:0] OFS_MISC0 = 4'h2;
    localparam logic [ADDR_W-1:0] OFS_CAL   = 4'h8;
    localparam logic [ADDR_W-1:0] OFS_SEC   = 4'h9;
    localparam logic [ADDR_W-1:0] OFS_MIN   = 4'hA;
    localparam logic [ADDR_W-1:0] OFS_HOUR  = 4'hB;
    localparam logic [ADDR_W-1:0] OFS_DOW   = 4'hC;
    localparam logic [ADDR_W-1:0] OFS_DATE  = 4'hD;
    localparam logic [ADDR_W-1:0] OFS_MON   = 4'hE;
    localparam logic [ADDR_W-1:0] OFS_YEAR  = 4'hF;

    localparam int FLG_CAP = 0;
    localparam int FLG_STG = 1;
    localparam int FLG_LOWV = 5;
    localparam int CAL_HALT = 7;
    localparam int TRIM_W = 6;

    typedef struct packed {
        logic [7:0] cent;
        logic [7:0] year;
        logic [4:0] mon;
        logic [5:0] date;
        logic [2:0] dow;
        logic [5:0] hour;
        logic [6:0] min;
        logic [6:0] sec;
    } rtc_time_t;

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic [6:0] bcd_to_bin(input logic [7:0] v);
        logic [6:0] hi;
        hi = {3'b0, v[7:4]};
        return (hi << 3) + (hi << 1) + {3'b0, v[3:0]};
    endfunction

    function automatic logic [5:0] last_day(input logic [4:0] mon,
                                            input logic [7:0] yr,
                                            input logic [7:0] cen);
        logic [6:0] yb;
        logic [6:0] cb;
        logic       leap;
        yb   = bcd_to_bin(yr);
        cb   = bcd_to_bin(cen);
        leap = (yb[1:0] == 2'd0) && ((yb != 7'd0) || (cb[1:0] == 2'd0));
        case (mon)
            5'h02:                      return leap ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
            default:                    return 6'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_time_step.sv
module rtc_time_step
    import rtc_bcd_pkg::*;
(
    input  rtc_time_t cur_i,
    output rtc_time_t nxt_o
);
    logic       sec_wrap, min_wrap, hr_wrap, day_wrap, mon_wrap, yr_wrap;
    logic [5:0] dim;

    always_comb begin
        dim      = last_day(cur_i.mon, cur_i.year, cur_i.cent);
        sec_wrap = cur_i.sec  >= 7'h59;
        min_wrap = cur_i.min  >= 7'h59;
        hr_wrap  = cur_i.hour >= 6'h23;
        day_wrap = cur_i.date >= dim;
        mon_wrap = cur_i.mon  >= 5'h12;
        yr_wrap  = cur_i.year >= 8'h99;

        nxt_o     = cur_i;
        nxt_o.sec = sec_wrap ? '0 : 7'(bcd_inc({1'b0, cur_i.sec}));
        if (sec_wrap) begin
            nxt_o.min = min_wrap ? '0 : 7'(bcd_inc({1'b0, cur_i.min}));
            if (min_wrap) begin
                nxt_o.hour = hr_wrap ? '0 : 6'(bcd_inc({2'b0, cur_i.hour}));
                if (hr_wrap) begin
                    nxt_o.dow  = (cur_i.dow >= 3'd7 || cur_i.dow == 3'd0) ? 3'd1 : cur_i.dow + 3'd1;
                    nxt_o.date = day_wrap ? 6'h01 : 6'(bcd_inc({2'b0, cur_i.date}));
                    if (day_wrap) begin
                        nxt_o.mon = mon_wrap ? 5'h01 : 5'(bcd_inc({3'b0, cur_i.mon}));
                        if (mon_wrap) begin
                            nxt_o.year = yr_wrap ? 8'h00 : bcd_inc(cur_i.year);
                            if (yr_wrap)
                                nxt_o.cent = (cur_i.cent >= 8'h99) ? 8'h00 : bcd_inc(cur_i.cent);
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/rtc_rd_mux.sv
module rtc_rd_mux
    import rtc_bcd_pkg::*;
(
    input  logic [ADDR_W-1:0]             addr_i,
    input  rtc_time_t                     view_i,
    input  logic [DATA_W-1:0]             flags_i,
    input  logic [DATA_W-1:0]             cal_i,
    input  logic [MISC_N-1:0][DATA_W-1:0] misc_i,
    output logic [DATA_W-1:0]             rdata_o
);
    always_comb begin
        rdata_o = '0;
        for (int k = 0; k < MISC_N; k++)
            if (addr_i == 4'(OFS_MISC0 + k)) rdata_o = misc_i[k];
        case (addr_i)
            OFS_FLAGS: rdata_o = flags_i;
            OFS_CENT:  rdata_o = view_i.cent;
            OFS_CAL:   rdata_o = cal_i;
            OFS_SEC:   rdata_o = {1'b0, view_i.sec};
            OFS_MIN:   rdata_o = {1'b0, view_i.min};
            OFS_HOUR:  rdata_o = {2'b0, view_i.hour};
            OFS_DOW:   rdata_o = {5'b0, view_i.dow};
            OFS_DATE:  rdata_o = {2'b0, view_i.date};
            OFS_MON:   rdata_o = {3'b0, view_i.mon};
            OFS_YEAR:  rdata_o = view_i.year;
            default:   ;
        endcase
    end
endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
    import rtc_bcd_pkg::*;
#(
    parameter logic [7:0] RST_CENT = 8'h20,
    parameter logic [7:0] RST_YEAR = 8'h00,
    parameter logic [4:0] RST_MON  = 5'h01,
    parameter logic [5:0] RST_DATE = 6'h01,
    parameter logic [2:0] RST_DOW  = 3'd1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       lowv_i,
    input  logic [3:0] bus_addr_i,
    input  logic       bus_wr_i,
    input  logic [7:0] bus_wdata_i,
    output logic [7:0] bus_rdata_o
);
    typedef struct packed {
        rtc_time_t                     cur;
        rtc_time_t                     stg;
        rtc_time_t                     snap;
        logic                          cap;
        logic                          stage;
        logic                          halt;
        logic [TRIM_W-1:0]             trim;
        logic [MISC_N-1:0][DATA_W-1:0] misc;
    } state_t;

    state_t    st_d, st_q;
    rtc_time_t step_w;
    rtc_time_t view_w;
    logic      flags_wr, open_w, commit_w;
    logic [DATA_W-1:0] flags_w, cal_w;

    rtc_time_t cur_q, stg_q, snap_q;
    logic      cap_q, stage_q, halt_q;
    assign cur_q   = st_q.cur;
    assign stg_q   = st_q.stg;
    assign snap_q  = st_q.snap;
    assign cap_q   = st_q.cap;
    assign stage_q = st_q.stage;
    assign halt_q  = st_q.halt;

    rtc_time_step u_step (
        .cur_i (st_q.cur),
        .nxt_o (step_w)
    );

    always_comb begin
        st_d     = st_q;
        flags_wr = bus_wr_i && (bus_addr_i == OFS_FLAGS);
        open_w   = flags_wr && !st_q.stage && bus_wdata_i[FLG_STG];
        commit_w = flags_wr && st_q.stage && !bus_wdata_i[FLG_STG];

        if (tick_i && !st_q.halt) st_d.cur = step_w;

        if (flags_wr) begin
            st_d.cap   = bus_wdata_i[FLG_CAP];
            st_d.stage = bus_wdata_i[FLG_STG];
            if (!st_q.cap && bus_wdata_i[FLG_CAP]) st_d.snap = st_q.cur;
        end
        if (open_w)   st_d.stg = st_q.cur;
        if (commit_w) st_d.cur = st_q.stg;

        if (bus_wr_i && st_q.stage) begin
            case (bus_addr_i)
                OFS_CENT: st_d.stg.cent = bus_wdata_i;
                OFS_SEC:  st_d.stg.sec  = bus_wdata_i[6:0];
                OFS_MIN:  st_d.stg.min  = bus_wdata_i[6:0];
                OFS_HOUR: st_d.stg.hour = bus_wdata_i[5:0];
                OFS_DOW:  st_d.stg.dow  = bus_wdata_i[2:0];
                OFS_DATE: st_d.stg.date = bus_wdata_i[5:0];
                OFS_MON:  st_d.stg.mon  = bus_wdata_i[4:0];
                OFS_YEAR: st_d.stg.year = bus_wdata_i;
                default:  ;
            endcase
        end

        if (bus_wr_i && bus_addr_i == OFS_CAL) begin
            st_d.halt = bus_wdata_i[CAL_HALT];
            st_d.trim = bus_wdata_i[TRIM_W-1:0];
        end
        for (int k = 0; k < MISC_N; k++)
            if (bus_wr_i && bus_addr_i == 4'(OFS_MISC0 + k)) st_d.misc[k] = bus_wdata_i;

        view_w  = st_q.cap ? st_q.snap : st_q.cur;
        flags_w = '0;
        flags_w[FLG_CAP]  = st_q.cap;
        flags_w[FLG_STG]  = st_q.stage;
        flags_w[FLG_LOWV] = lowv_i;
        cal_w   = {st_q.halt, 1'b0, st_q.trim};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.cur.cent <= RST_CENT;
            st_q.cur.year <= RST_YEAR;
            st_q.cur.mon  <= RST_MON;
            st_q.cur.date <= RST_DATE;
            st_q.cur.dow  <= RST_DOW;
            st_q.halt     <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    rtc_rd_mux u_rd (
        .addr_i  (bus_addr_i),
        .view_i  (view_w),
        .flags_i (flags_w),
        .cal_i   (cal_w),
        .misc_i  (st_q.misc),
        .rdata_o (bus_rdata_o)
    );
endmodule

// File: rtl/rtc_bcd_core_chk.sv
module rtc_bcd_core_chk
    import rtc_bcd_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       tick_i,
    input logic [3:0] bus_addr_i,
    input logic       bus_wr_i,
    input logic [7:0] bus_wdata_i,
    input logic [7:0] bus_rdata_o,
    input rtc_time_t  cur_q,
    input rtc_time_t  stg_q,
    input rtc_time_t  snap_q,
    input logic       cap_q,
    input logic       stage_q,
    input logic       halt_q
);
    logic commit_c;
    assign commit_c = bus_wr_i && bus_addr_i == OFS_FLAGS && stage_q && !bus_wdata_i[FLG_STG];

    p_halt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_q && !commit_c) |=> cur_q == $past(cur_q));

    p_commit_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stage_q) |-> cur_q == $past(stg_q));

    p_snap_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_q && $past(cap_q)) |-> snap_q == $past(snap_q));

    p_tick_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !halt_q && !commit_c) |=> cur_q != $past(cur_q));

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !commit_c) |=> cur_q == $past(cur_q));

    p_sec_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_i == OFS_SEC) |-> bus_rdata_o[7] == 1'b0);

    p_dow_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_i == OFS_DOW) |-> bus_rdata_o[7:3] == 5'd0);

    p_flag_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_i == OFS_FLAGS) |-> (bus_rdata_o[7:6] == 2'd0 && bus_rdata_o[4:2] == 3'd0));
endmodule

bind rtc_bcd_core rtc_bcd_core_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wr_i    (bus_wr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .cur_q       (cur_q),
    .stg_q       (stg_q),
    .snap_q      (snap_q),
    .cap_q       (cap_q),
    .stage_q     (stage_q),
    .halt_q      (halt_q)
);

// File: tb/rtc_bcd_core_bench.sv
module rtc_bcd_core_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       lowv_i = 1'b0;
    logic [3:0] bus_addr_i = '0;
    logic       bus_wr_i = 1'b0;
    logic [7:0] bus_wdata_i = '0;
    logic [7:0] bus_rdata_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    int m_sec, m_min, m_hour, m_dow, m_date, m_mon, m_year, m_cent;

    always #4 clk = ~clk;

    rtc_bcd_core u_rtc_bcd_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .lowv_i      (lowv_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wr_i    (bus_wr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o)
    );

    function automatic int b2(input int v);
        return (v / 10) * 16 + (v % 10);
    endfunction

    function automatic int dim(input int mo, input int y, input int c);
        bit leap;
        leap = (y % 4 == 0) && (y != 0 || c % 4 == 0);
        if (mo == 2) return leap ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic model_step();
        m_sec++;
        if (m_sec == 60) begin
            m_sec = 0; m_min++;
            if (m_min == 60) begin
                m_min = 0; m_hour++;
                if (m_hour == 24) begin
                    m_hour = 0;
                    m_dow = (m_dow == 7) ? 1 : m_dow + 1;
                    m_date++;
                    if (m_date > dim(m_mon, m_year, m_cent)) begin
                        m_date = 1; m_mon++;
                        if (m_mon == 13) begin
                            m_mon = 1; m_year++;
                            if (m_year == 100) begin
                                m_year = 0;
                                m_cent = (m_cent == 99) ? 0 : m_cent + 1;
                            end
                        end
                    end
                end
            end
        end
    endtask

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic bus_write(input int a, input int d);
        @(negedge clk);
        bus_addr_i  = 4'(a);
        bus_wdata_i = 8'(d);
        bus_wr_i    = 1'b1;
        @(negedge clk);
        bus_wr_i    = 1'b0;
    endtask

    task automatic bus_read(input int a, output int d);
        @(negedge clk);
        bus_addr_i = 4'(a);
        #1;
        d = int'(bus_rdata_o);
    endtask

    task automatic pulse(input bit adv);
        @(negedge clk);
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        if (adv) model_step();
    endtask

    task automatic set_time(input int c, input int y, input int mo, input int d,
                            input int dw, input int h, input int mi, input int s);
        bus_write(0, 8'h02);
        bus_write(1, b2(c));  bus_write(15, b2(y));  bus_write(14, b2(mo));
        bus_write(13, b2(d)); bus_write(12, dw);     bus_write(11, b2(h));
        bus_write(10, b2(mi)); bus_write(9, b2(s));
        bus_write(0, 8'h00);
        m_cent = c; m_year = y; m_mon = mo; m_date = d;
        m_dow = dw; m_hour = h; m_min = mi; m_sec = s;
    endtask

    task automatic check_time(input string req);
        int v;
        bus_write(0, 8'h01);
        bus_read(9, v);  chk(req, "sec", v, b2(m_sec));
        bus_read(10, v); chk(req, "min", v, b2(m_min));
        bus_read(11, v); chk(req, "hour", v, b2(m_hour));
        bus_read(12, v); chk(req, "dow", v, m_dow);
        bus_read(13, v); chk(req, "date", v, b2(m_date));
        bus_read(14, v); chk(req, "month", v, b2(m_mon));
        bus_read(15, v); chk(req, "year", v, b2(m_year));
        bus_read(1, v);  chk(req, "century", v, b2(m_cent));
        bus_write(0, 8'h00);
    endtask

    task automatic corner(input string req, input int c, input int y, input int mo,
                          input int d, input int dw, input int h, input int mi, input int s);
        set_time(c, y, mo, d, dw, h, mi, s);
        pulse(1);
        check_time(req);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
        end
    end

    initial begin
        int v;
        void'($urandom(32'd4242));
        m_cent = 20; m_year = 0; m_mon = 1; m_date = 1;
        m_dow = 1; m_hour = 0; m_min = 0; m_sec = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: reset state, read live without capture
        bus_read(9, v);  chk("R2", "sec", v, 0);
        bus_read(10, v); chk("R2", "min", v, 0);
        bus_read(11, v); chk("R2", "hour", v, 0);
        bus_read(12, v); chk("R2", "dow", v, 1);
        bus_read(13, v); chk("R2", "date", v, 1);
        bus_read(14, v); chk("R2", "month", v, 1);
        bus_read(15, v); chk("R2", "year", v, 0);
        bus_read(1, v);  chk("R2", "century", v, 8'h20);
        bus_read(0, v);  chk("R2", "flags", v, 0);
        bus_read(8, v);  chk("R2", "calibration", v, 8'h80);

        // R3: halted after reset, trim storage, halt again
        pulse(0); pulse(0); pulse(0);
        bus_read(9, v);  chk("R3", "sec while halted", v, 0);
        bus_write(8, 8'h7F);
        bus_read(8, v);  chk("R3", "cal readback", v, 8'h3F);
        pulse(1);
        bus_read(9, v);  chk("R3", "sec after release", v, 1);
        bus_write(8, 8'hA5);
        bus_read(8, v);  chk("R3", "cal halt readback", v, 8'hA5);
        pulse(0);
        bus_read(9, v);  chk("R3", "sec halted again", v, 1);
        bus_write(8, 8'h00);
        bus_read(8, v);  chk("R3", "cal cleared", v, 0);

        // R1: plain storage bytes
        for (int k = 2; k < 8; k++) bus_write(k, (k * 37 + 8'h5A) & 8'hFF);
        for (int k = 2; k < 8; k++) begin
            bus_read(k, v);
            chk("R1", "storage byte", v, (k * 37 + 8'h5A) & 8'hFF);
        end

        // R10: low-voltage flag and reserved flag bits
        lowv_i = 1'b1;
        bus_read(0, v);  chk("R10", "lowv high", v, 8'h20);
        bus_write(0, 8'hFC);
        bus_read(0, v);  chk("R10", "reserved not settable", v, 8'h20);
        lowv_i = 1'b0;
        bus_read(0, v);  chk("R10", "lowv low", v, 0);

        // R4: atomic commit, partial write, dropped tick, closed-window writes
        set_time(20, 24, 6, 15, 6, 12, 34, 56);
        check_time("R4");
        bus_write(0, 8'h02);
        bus_write(10, b2(7));
        pulse(0);
        bus_read(9, v);  chk("R4", "live sec during window", v, b2(57));
        bus_read(10, v); chk("R4", "staged min hidden", v, b2(34));
        bus_write(0, 8'h00);
        m_min = 7; m_sec = 56;
        check_time("R4");
        bus_write(9, 8'h11);
        bus_read(9, v);  chk("R4", "closed-window write ignored", v, b2(56));

        // R5: coherent capture while counters run
        bus_write(0, 8'h01);
        pulse(1); pulse(1);
        bus_read(9, v);  chk("R5", "frozen sec", v, b2(56));
        bus_read(0, v);  chk("R5", "capture flag", v, 8'h01);
        bus_write(0, 8'h00);
        bus_read(9, v);  chk("R5", "live sec after release", v, b2(58));

        // R6 R7 R8: rollover corners
        corner("R6 R7 R8 new year", 20, 23, 12, 31, 7, 23, 59, 59);
        corner("R7 leap feb", 20, 24, 2, 28, 3, 23, 59, 59);
        corner("R7 common feb", 20, 23, 2, 28, 2, 23, 59, 59);
        corner("R7 century 21 non-leap", 21, 0, 2, 28, 1, 23, 59, 59);
        corner("R7 century 20 leap", 20, 0, 2, 28, 1, 23, 59, 59);
        corner("R7 century carry", 20, 99, 12, 31, 4, 23, 59, 59);
        corner("R7 century wrap", 99, 99, 12, 31, 5, 23, 59, 59);
        corner("R7 thirty-day month", 20, 24, 4, 30, 2, 23, 59, 59);
        corner("R6 minute carry", 20, 24, 5, 5, 1, 12, 0, 59);
        corner("R6 hour carry", 20, 24, 5, 5, 1, 10, 59, 59);
        corner("R8 dow step", 20, 24, 5, 5, 3, 23, 59, 59);

        // R9: field widths mask upper bits
        bus_write(0, 8'h02);
        bus_write(9, 8'hD9);  bus_write(10, 8'hC5); bus_write(11, 8'hE3);
        bus_write(12, 8'hFF); bus_write(13, 8'hD2); bus_write(14, 8'hE9);
        bus_write(0, 8'h00);
        bus_read(9, v);  chk("R9", "sec width", v, 8'h59);
        bus_read(10, v); chk("R9", "min width", v, 8'h45);
        bus_read(11, v); chk("R9", "hour width", v, 8'h23);
        bus_read(12, v); chk("R9", "dow width", v, 8'h07);
        bus_read(13, v); chk("R9", "date width", v, 8'h12);
        bus_read(14, v); chk("R9", "month width", v, 8'h09);

        // R6 R7 R8 random: valid start points and bursts of ticks
        for (int it = 0; it < 30; it++) begin
            int c, y, mo, d, n;
            c  = $urandom % 100;
            y  = $urandom % 100;
            mo = 1 + $urandom % 12;
            d  = 1 + $urandom % dim(mo, y, c);
            set_time(c, y, mo, d, 1 + $urandom % 7, $urandom % 24, $urandom % 60, $urandom % 60);
            n = 1 + $urandom % 300;
            for (int t = 0; t < n; t++) pulse(1);
            check_time("R7 random");
        end

        done = 1;
        report();
    end
endmodule